// File: doc/BRIEF.md
# Horizontal Sync Conditioner

This block takes a raw horizontal sync line, already in the pixel clock domain but not yet synchronized, and turns it into a clean, well-defined line sync for the rest of a display pipeline. It works out for itself which level of the incoming sync is the active pulse. It measures the line period in pixel clocks. On every line start it regenerates a pulse of programmable width and output polarity. That pulse is delayed so that it leaves the block in step with a fixed-latency pixel data path. A data-valid flag marks when that path has filled after reset.

A coast input lets the system ride through disturbed sync, for example missing pulses, equalization pulses or extra pulses during vertical blanking. While coast is asserted, incoming edges are ignored and line starts are produced from the last measured period. When coast is tied inactive, every active leading edge of the input starts a line. Configuration (output polarity and pulse width) comes from static register inputs.

Top module: `lsc_top`

## Requirements
- R1: `inPolHigh` reports the detected input polarity (1 = active high). The shorter of the high and low phases between successive rising edges of the synchronized input is taken as the active pulse. The decision changes only when two consecutive lines give the same result. After reset it is 0 (active low).
- R2: With `outPolHigh` = 1 the regenerated pulse on `syncOut` is a high level and the idle level is low. With `outPolHigh` = 0 both levels are inverted.
- R3: The regenerated pulse lasts `pulseWidth` pixel clocks. A programmed width of 0 produces a pulse of one pixel clock.
- R4: Once a line period P has been measured, a programmed width greater than P-1 is clamped to P-1 pixel clocks.
- R5: The leading edge of `syncOut` appears 26 pixel clocks after the active leading edge of `syncIn`: 2 clocks of synchronizer, 1 clock of regeneration and 23 clocks of data-path latency.
- R6: After reset, `dataValid` stays low for the first 22 clock edges and is high from the 23rd edge on.
- R7: With coast inactive, successive `syncOut` leading edges follow the spacing of the input's active leading edges, including after the input period changes.
- R8: While coast is asserted, input sync edges of any kind are ignored and the stored period is frozen. Line starts continue every P clocks, where P is the last measured period.
- R9: While `dataValid` is low, `syncOut` holds its idle level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Raw horizontal sync, either polarity |
| coastIn | input | 1 | Asynchronous coast request, active high |
| outPolHigh | input | 1 | Output polarity select: 1 = active-high pulse |
| pulseWidth | input | WID_W (8) | Output pulse width in pixel clocks |
| syncOut | output | 1 | Regenerated, latency-matched sync |
| dataValid | output | 1 | High once the data pipeline has filled |
| inPolHigh | output | 1 | Detected input polarity: 1 = active high |

## Verification
The bench builds the block with its default parameters: a 12-bit period counter, an 8-bit width field, a latency of 23 and a two-stage synchronizer. It drives lines only 13, 20 and 27 clocks long. At those lengths a dozen lines fit into a few hundred cycles. That allows a near-complete sweep over both input polarities, both output polarities and widths from zero through the clamp limit up to 255. Each sweep point settles polarity detection, checks the exact 26-clock offset and measures pulse spacing and width. Separate runs cover a change of period and a coast window that contains missing pulses and a burst of extra pulses.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic lineStart;    // one-cycle line start
    logic coasting;     // synchronized coast is active
    logic periodValid;  // a full line period has been measured
  } lsc_strobe_t;

endpackage

// File: rtl/lsc_sync2.sv
module lsc_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
  import lsc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncS,
  input  logic             coastS,
  output lsc_strobe_t      strobe,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] widthLimit,
  output logic             polHigh
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic             sPrev;
  logic             riseEdge, fallEdge, leadEdge, edgeOk;
  logic [CNT_W-1:0] highCnt, lowCnt;
  logic             seenRise, candValid, lastCand, cand;
  logic [CNT_W-1:0] phase;
  logic             haveRef, periodValid;
  logic             freeRunHit, lineStart;

  assign riseEdge = syncS & ~sPrev;
  assign fallEdge = ~syncS & sPrev;
  assign leadEdge = polHigh ? riseEdge : fallEdge;
  assign edgeOk   = ~coastS;

  // shorter phase is the active one
  assign cand = (highCnt < lowCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sPrev <= 1'b0;
    else       sPrev <= syncS;
  end

  // polarity detection over each line (rising edge to rising edge)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt   <= '0;
      lowCnt    <= '0;
      seenRise  <= 1'b0;
      candValid <= 1'b0;
      lastCand  <= 1'b0;
      polHigh   <= 1'b0;
    end else if (riseEdge && edgeOk) begin
      highCnt  <= ONE;
      lowCnt   <= '0;
      seenRise <= 1'b1;
      if (seenRise) begin
        lastCand  <= cand;
        candValid <= 1'b1;
        if (candValid && (cand == lastCand)) polHigh <= cand;
      end
    end else if (riseEdge) begin
      highCnt <= ONE;
      lowCnt  <= '0;
    end else if (syncS) begin
      if (highCnt != CNT_MAX) highCnt <= highCnt + ONE;
    end else begin
      if (lowCnt != CNT_MAX) lowCnt <= lowCnt + ONE;
    end
  end

  // line start selection: tracked edge or free-run
  assign freeRunHit = periodValid && (phase == period - ONE);
  assign lineStart  = coastS ? freeRunHit : leadEdge;

  // line phase counter and period measurement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= '0;
      haveRef     <= 1'b0;
      periodValid <= 1'b0;
      period      <= '0;
    end else begin
      if (lineStart)              phase <= '0;
      else if (phase != CNT_MAX)  phase <= phase + ONE;

      if (leadEdge && edgeOk) begin
        haveRef <= 1'b1;
        if (haveRef) begin
          period      <= (phase == CNT_MAX) ? CNT_MAX : phase + ONE;
          periodValid <= 1'b1;
        end
      end
    end
  end

  assign widthLimit = periodValid ? (period - ONE) : CNT_MAX;

  assign strobe.lineStart   = lineStart;
  assign strobe.coasting    = coastS;
  assign strobe.periodValid = periodValid;

endmodule

// File: rtl/lsc_dpath.sv
module lsc_dpath
  import lsc_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int WID_W   = 8,
  parameter int LATENCY = 23
) (
  input  logic             clk,
  input  logic             rstN,
  input  lsc_strobe_t      strobe,
  input  logic [CNT_W-1:0] widthLimit,
  input  logic [WID_W-1:0] cfgWidth,
  input  logic             outPolHigh,
  output logic             rawPulse,
  output logic             syncOut,
  output logic             dataValid
);

  localparam int               FILL_W = $clog2(LATENCY + 2);
  localparam logic [FILL_W-1:0] FILL_END = FILL_W'(LATENCY);
  localparam logic [CNT_W-1:0]  ONE = CNT_W'(1);

  logic [CNT_W-1:0] reqW, limW, effW, remain;
  logic             delayed;
  logic [FILL_W-1:0] fillCnt;

  // width: zero means one, then clamp inside the line
  assign reqW   = (cfgWidth == '0) ? ONE : CNT_W'(cfgWidth);
  assign limW   = (widthLimit == '0) ? ONE : widthLimit;
  assign effW   = (reqW > limW) ? limW : reqW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawPulse <= 1'b0;
      remain   <= '0;
    end else if (strobe.lineStart) begin
      rawPulse <= 1'b1;
      remain   <= effW - ONE;
    end else if (remain != '0) begin
      remain   <= remain - ONE;
    end else begin
      rawPulse <= 1'b0;
    end
  end

  // latency matching delay line
  generate
    if (LATENCY == 0) begin : g_nodly
      assign delayed = rawPulse;
    end else begin : g_dly
      logic [LATENCY-1:0] stage;
      for (genvar i = 0; i < LATENCY; i++) begin : g_st
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)       stage[i] <= 1'b0;
          else if (i == 0) stage[i] <= rawPulse;
          else             stage[i] <= stage[(i == 0) ? 0 : i-1];
        end
      end
      assign delayed = stage[LATENCY-1];
    end
  endgenerate

  assign syncOut = outPolHigh ? delayed : ~delayed;

  // pipeline fill tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 fillCnt <= '0;
    else if (fillCnt != FILL_END) fillCnt <= fillCnt + FILL_W'(1);
  end

  assign dataValid = (fillCnt == FILL_END);

endmodule

// File: rtl/lsc_top.sv
module lsc_top
  import lsc_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int WID_W       = 8,
  parameter int LATENCY     = 23,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic             coastIn,
  input  logic             outPolHigh,
  input  logic [WID_W-1:0] pulseWidth,
  output logic             syncOut,
  output logic             dataValid,
  output logic             inPolHigh
);

  logic             syncS, coastS, rawPulse;
  lsc_strobe_t      strobe;
  logic [CNT_W-1:0] period, widthLimit;

  lsc_sync2 #(.STAGES(SYNC_STAGES)) u_syncIn (
    .clk(clk), .rstN(rstN), .d(syncIn), .q(syncS)
  );

  lsc_sync2 #(.STAGES(SYNC_STAGES)) u_syncCoast (
    .clk(clk), .rstN(rstN), .d(coastIn), .q(coastS)
  );

  lsc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .syncS(syncS), .coastS(coastS),
    .strobe(strobe), .period(period), .widthLimit(widthLimit),
    .polHigh(inPolHigh)
  );

  lsc_dpath #(.CNT_W(CNT_W), .WID_W(WID_W), .LATENCY(LATENCY)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .widthLimit(widthLimit),
    .cfgWidth(pulseWidth), .outPolHigh(outPolHigh), .rawPulse(rawPulse),
    .syncOut(syncOut), .dataValid(dataValid)
  );

endmodule

// File: rtl/lsc_chk.sv
module lsc_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             syncOut,
  input logic             dataValid,
  input logic             outPolHigh,
  input logic             lineStart,
  input logic             coasting,
  input logic             rawPulse,
  input logic [CNT_W-1:0] period
);

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> dataValid);

  // R9
  quiet_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> (syncOut == !outPolHigh));

  // R3
  regen_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> rawPulse);

  // R8
  coast_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    coasting |=> $stable(period));

  // R7
  start_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && !coasting) |=> !lineStart);

endmodule

bind lsc_top lsc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .syncOut(syncOut), .dataValid(dataValid),
  .outPolHigh(outPolHigh), .lineStart(strobe.lineStart),
  .coasting(strobe.coasting), .rawPulse(rawPulse), .period(period)
);

// File: tb/lsc_top_bench.sv
module lsc_top_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       syncIn = 1'b1;
  logic       coastIn = 1'b0;
  logic       outPolHigh = 1'b1;
  logic [7:0] pulseWidth = 8'd0;
  logic       syncOut, dataValid, inPolHigh;

  lsc_top u_lsc_top (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .coastIn(coastIn),
    .outPolHigh(outPolHigh), .pulseWidth(pulseWidth),
    .syncOut(syncOut), .dataValid(dataValid), .inPolHigh(inPolHigh)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nCmp = 0;
  int nBad = 0;

  // output pulse monitor
  int startCyc[64];
  int widthOf[64];
  int nPulse = 0;
  int run = 0;
  bit prevAct = 1'b0;
  int lastIn = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if ((syncOut == outPolHigh) && !prevAct) begin
        if (nPulse < 64) startCyc[nPulse] = cyc;
        run = 1;
      end else if (syncOut == outPolHigh) begin
        run = run + 1;
      end else if (prevAct) begin
        if (nPulse < 64) widthOf[nPulse] = run;
        nPulse = nPulse + 1;
      end
      prevAct = (syncOut == outPolHigh);
    end
  end

  task automatic chk(string req, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int effWidth(int cfg, int p);
    int w = (cfg == 0) ? 1 : cfg;
    if (w > p - 1) w = p - 1;
    return w;
  endfunction

  task automatic doReset(bit inPol);
    rstN = 1'b0;
    coastIn = 1'b0;
    syncIn = !inPol;
    repeat (3) @(negedge clk);
    nPulse = 0; run = 0; prevAct = 1'b0;
    rstN = 1'b1;
    for (int k = 1; k <= 23; k++) begin
      @(negedge clk);
      if (k == 1) chk("R1 reset polarity", inPolHigh, 0);
      if (k == 1 || k == 22) begin
        chk("R6 valid low during fill", dataValid, 0);
        chk("R9 idle during fill", syncOut, !outPolHigh);
      end
      if (k == 23) chk("R6 valid after fill", dataValid, 1);
    end
  endtask

  task automatic oneLine(bit inPol, int p, int a);
    lastIn = cyc;
    syncIn = inPol;
    repeat (a) @(negedge clk);
    syncIn = !inPol;
    repeat (p - a) @(negedge clk);
  endtask

  task automatic checkTail(int p, int w, string wReq);
    chk("R7 enough pulses", (nPulse >= 5) ? 1 : 0, 1);
    if (nPulse >= 5) begin
      for (int i = nPulse - 4; i < nPulse; i++) begin
        chk("R7 start spacing", startCyc[i] - startCyc[i-1], p);
        chk(wReq, widthOf[i], w);
      end
    end
  endtask

  task automatic sweepPoint(bit inPol, bit oPol, int cfg, int p);
    int w;
    outPolHigh = oPol;
    pulseWidth = 8'(cfg);
    doReset(inPol);
    repeat (12) oneLine(inPol, p, 4);
    repeat (60) @(negedge clk);
    w = effWidth(cfg, p);
    checkTail(p, w, ((cfg == 0 ? 1 : cfg) > p - 1) ? "R4 clamped width" : "R3 width");
    chk("R5 latency", startCyc[nPulse-1] - lastIn, 26);
    chk("R1 detected polarity", inPolHigh, inPol);
    chk("R2 idle level", syncOut, !oPol);
  endtask

  initial begin
    #(200000 * 20);
    nCmp++; nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int widths[7] = '{0, 1, 2, 7, 19, 30, 255};
    int widths13[3] = '{0, 12, 200};
    @(negedge clk);

    // R1 R2 R3 R4 R5: polarity and width sweep
    for (int ip = 0; ip < 2; ip++)
      for (int op = 0; op < 2; op++) begin
        for (int wi = 0; wi < 7; wi++) sweepPoint(ip[0], op[0], widths[wi], 20);
        for (int wi = 0; wi < 3; wi++) sweepPoint(ip[0], op[0], widths13[wi], 13);
      end

    // R7: period change from 20 to 27
    outPolHigh = 1'b0;
    pulseWidth = 8'd5;
    doReset(1'b1);
    repeat (8) oneLine(1'b1, 20, 4);
    repeat (8) oneLine(1'b1, 27, 4);
    repeat (60) @(negedge clk);
    checkTail(27, 5, "R3 width after period change");

    // R8: coast over missing and extra pulses
    outPolHigh = 1'b1;
    pulseWidth = 8'd3;
    doReset(1'b0);
    repeat (8) oneLine(1'b0, 20, 4);
    syncIn = 1'b0;
    repeat (4) @(negedge clk);
    syncIn = 1'b1;
    repeat (2) @(negedge clk);
    coastIn = 1'b1;
    repeat (14) @(negedge clk);
    repeat (40) @(negedge clk);
    for (int g = 0; g < 12; g++) begin
      syncIn = 1'b0;
      repeat (2) @(negedge clk);
      syncIn = 1'b1;
      repeat (5) @(negedge clk);
    end
    repeat (80) @(negedge clk);
    chk("R8 pulses kept coming", (nPulse >= 14) ? 1 : 0, 1);
    for (int i = 3; i < nPulse && i < 64; i++) begin
      chk("R8 free-run spacing", startCyc[i] - startCyc[i-1], 20);
      chk("R8 free-run width", widthOf[i], 3);
    end
    chk("R8 polarity held", inPolHigh, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule